// File: doc/BRIEF.md
# Fully-Associative Tag Cache with Recency Ordering

This block models the lookup and replacement side of a small fully-associative cache. It keeps no data, only an address tag and a valid flag for each of eight one-word entries. Each request presents a full word address. All valid tags are compared with it in parallel, and one clock later the block answers with a hit flag and the entry number that now holds the address.

Replacement follows an explicit ordered list of entry numbers, from most recently used to least recently used. Every access moves the touched entry to the front of the list. On a miss, the entry at the tail of the list is overwritten with the new address. Two saturating counters, one for accesses and one for hits, are exported so that a hit ratio can be worked out outside the block. The full recency list is also exported for observation.

Top module: `fa_tag_cache`

## Requirements
- R1: After synchronous reset, both counters read 0, every entry is invalid, `rsp_valid` is low, and the recency list reads entry 7,6,5,4,3,2,1,0 from slot 0 to slot 7. Slot s is carried in `recency_order[3s+2:3s]`, so the value is 24'o01234567.
- R2: A request sampled with `req_valid` high at a rising edge produces `rsp_valid` high for exactly the following cycle. `rsp_valid` is low in every other cycle.
- R3: A request hits when some valid entry's tag equals all 32 address bits. `rsp_hit` is then 1 and `rsp_idx` is the lowest-numbered matching entry.
- R4: An invalid entry never matches, so address 0 presented right after reset is a miss.
- R5: On a hit, the hit entry moves to slot 0. Entries that were ahead of it each move one slot toward the tail, and entries behind it keep their slots.
- R6: On a miss, the victim is the entry held in slot 7. `rsp_hit` is 0, `rsp_idx` is the victim, the victim's tag takes the request address and becomes valid, and the victim moves to slot 0.
- R7: Tag and list updates commit at the same edge that registers the response, so a request in the very next cycle sees them.
- R8: `access_count` increments on every request and `hit_count` increments only on hits.
- R9: Both counters hold at their all-ones value instead of wrapping.
- R10: The recency list is at all times a permutation of the entry numbers 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Word address looked up |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | 1 on hit, 0 on miss |
| rsp_idx | output | 3 | Entry that was hit or refilled |
| hit_count | output | 32 | Saturating hit counter |
| access_count | output | 32 | Saturating access counter |
| recency_order | output | 24 | Recency list, slot s in bits [3s+2:3s], slot 0 most recent |

## Verification
The assertions check every cycle that the recency list stays a permutation, that a response follows each request by exactly one cycle, and that the reported entry lands in slot 0. They also check that a miss reports the entry that was at the tail one cycle earlier and that both counters step correctly up to saturation. Only the bench's scenarios can show that the hit/miss decision and the whole list order agree with an independent model over long mixed traces. The same holds for address 0 missing after reset, for back-to-back requests seeing each other's refills, and for the counters reaching their saturated values, which is shown on a narrow-counter instance.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;

    localparam int unsigned ENTRIES   = 8;
    localparam int unsigned ADDR_BITS = 32;
    localparam int unsigned CNT_BITS  = 32;
    localparam int unsigned IDX_BITS  = $clog2(ENTRIES);

    typedef logic [IDX_BITS-1:0]  entry_idx_t;
    typedef logic [ADDR_BITS-1:0] word_addr_t;

    typedef struct packed {
        logic       hit;
        entry_idx_t idx;
    } lookup_t;

    typedef struct packed {
        logic       valid;
        logic       hit;
        entry_idx_t idx;
    } response_t;

endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match
    import fa_cache_pkg::*;
#(
    parameter int unsigned N  = ENTRIES,
    parameter int unsigned AW = ADDR_BITS,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [AW-1:0] probe_addr,
    input  logic [AW-1:0] tags [N],
    input  logic [N-1:0]  valids,
    output logic          any_match,
    output logic [IW-1:0] match_idx
);

    logic [N-1:0] match_vec;

    generate
        for (genvar e = 0; e < N; e++) begin : g_cmp
            assign match_vec[e] = valids[e] && (tags[e] == probe_addr);
        end
    endgenerate

    // lowest-numbered match wins: scan from the top so low entries overwrite
    always_comb begin
        match_idx = '0;
        for (int e = N - 1; e >= 0; e--) begin
            if (match_vec[e]) begin
                match_idx = IW'(e);
            end
        end
    end

    assign any_match = |match_vec;

endmodule

// File: rtl/fa_recency_list.sv
module fa_recency_list
    import fa_cache_pkg::*;
#(
    parameter int unsigned N  = ENTRIES,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            touch,
    input  logic [IW-1:0]   touch_idx,
    output logic [IW-1:0]   tail_idx,
    output logic [N*IW-1:0] order_flat
);

    logic [IW-1:0] order_q [N];
    logic [IW-1:0] order_d [N];
    logic [IW-1:0] found_pos;

    // slot currently holding the touched entry
    always_comb begin
        found_pos = '0;
        for (int s = 0; s < N; s++) begin
            if (order_q[s] == touch_idx) begin
                found_pos = IW'(s);
            end
        end
    end

    // move-to-front: slots up to the found one shift back by one
    always_comb begin
        for (int s = 0; s < N; s++) begin
            order_d[s] = order_q[s];
        end
        if (touch) begin
            order_d[0] = touch_idx;
            for (int s = 1; s < N; s++) begin
                if (IW'(s) <= found_pos) begin
                    order_d[s] = order_q[s-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < N; s++) begin
                order_q[s] <= IW'(N - 1 - s);
            end
        end else begin
            for (int s = 0; s < N; s++) begin
                order_q[s] <= order_d[s];
            end
        end
    end

    assign tail_idx = order_q[N-1];

    generate
        for (genvar s = 0; s < N; s++) begin : g_flat
            assign order_flat[s*IW +: IW] = order_q[s];
        end
    endgenerate

endmodule

// File: rtl/fa_sat_counter.sv
module fa_sat_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/fa_tag_cache.sv
module fa_tag_cache
    import fa_cache_pkg::*;
#(
    parameter int unsigned N     = ENTRIES,
    parameter int unsigned AW    = ADDR_BITS,
    parameter int unsigned CNT_W = CNT_BITS,
    localparam int unsigned IW   = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [IW-1:0]   rsp_idx,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] access_count,
    output logic [N*IW-1:0] recency_order
);

    logic [AW-1:0] tag_q [N];
    logic [N-1:0]  valid_q;
    logic          any_match;
    logic [IW-1:0] match_idx;
    logic [IW-1:0] tail_idx;
    logic [IW-1:0] sel_idx;
    logic          refill;
    typedef struct packed {
        logic          valid;
        logic          hit;
        logic [IW-1:0] idx;
    } rsp_reg_t;
    rsp_reg_t rsp_q;

    fa_tag_match #(.N(N), .AW(AW), .IW(IW)) u_match (
        .probe_addr (req_addr),
        .tags       (tag_q),
        .valids     (valid_q),
        .any_match  (any_match),
        .match_idx  (match_idx)
    );

    fa_recency_list #(.N(N), .IW(IW)) u_order (
        .clk        (clk),
        .rst        (rst),
        .touch      (req_valid),
        .touch_idx  (sel_idx),
        .tail_idx   (tail_idx),
        .order_flat (recency_order)
    );

    assign sel_idx = any_match ? match_idx : tail_idx;
    assign refill  = req_valid && !any_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (refill) begin
            valid_q[tail_idx] <= 1'b1;
        end
    end

    generate
        for (genvar e = 0; e < N; e++) begin : g_tag
            always_ff @(posedge clk) begin
                if (rst) begin
                    tag_q[e] <= '0;
                end else if (refill && tail_idx == IW'(e)) begin
                    tag_q[e] <= req_addr;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= req_valid;
            rsp_q.hit   <= req_valid && any_match;
            rsp_q.idx   <= req_valid ? sel_idx : '0;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_idx   = rsp_q.idx;

    fa_sat_counter #(.W(CNT_W)) u_acc_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (req_valid),
        .count (access_count)
    );

    fa_sat_counter #(.W(CNT_W)) u_hit_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (req_valid && any_match),
        .count (hit_count)
    );

endmodule

// File: rtl/fa_tag_cache_chk.sv
module fa_tag_cache_chk #(
    parameter int unsigned N     = 8,
    parameter int unsigned CNT_W = 32,
    parameter int unsigned IW    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [IW-1:0]    rsp_idx,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] access_count,
    input logic [N*IW-1:0]  recency_order
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [N-1:0] seen;
    always_comb begin
        seen = '0;
        for (int s = 0; s < N; s++) begin
            seen[recency_order[s*IW +: IW]] = 1'b1;
        end
    end

    AST_ORDER_IS_PERMUTATION: assert property (@(posedge clk) disable iff (rst)
        &seen); // R10

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R2

    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R2

    AST_TOUCHED_AT_FRONT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> recency_order[IW-1:0] == rsp_idx); // R5

    AST_MISS_TAKES_TAIL: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_hit || rsp_idx == $past(recency_order[N*IW-1 -: IW]))); // R6

    AST_ACCESS_STEP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && access_count != TOP) |=> access_count == $past(access_count) + CNT_W'(1)); // R8

    AST_HIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit && $past(hit_count) != TOP) |-> hit_count == $past(hit_count) + CNT_W'(1)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        $past(access_count) == TOP |-> access_count == TOP); // R9

    AST_HITS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        hit_count <= access_count); // R8

endmodule

bind fa_tag_cache fa_tag_cache_chk #(.N(N), .CNT_W(CNT_W), .IW(IW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_idx       (rsp_idx),
    .hit_count     (hit_count),
    .access_count  (access_count),
    .recency_order (recency_order)
);

// File: tb/tb_fa_tag_cache.sv
`timescale 1ns/1ps
module tb_fa_tag_cache;

    localparam int N = 8;
    localparam int SMALL_W = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;

    logic        rsp_valid, rsp_hit;
    logic [2:0]  rsp_idx;
    logic [31:0] hit_count, access_count;
    logic [23:0] recency_order;

    logic        s_rsp_valid, s_rsp_hit;
    logic [2:0]  s_rsp_idx;
    logic [SMALL_W-1:0] s_hit_count, s_access_count;
    logic [23:0] s_recency_order;

    always #5 clk = ~clk;

    fa_tag_cache dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
        .hit_count(hit_count), .access_count(access_count),
        .recency_order(recency_order)
    );

    fa_tag_cache #(.CNT_W(SMALL_W)) dut_small (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(s_rsp_valid), .rsp_hit(s_rsp_hit), .rsp_idx(s_rsp_idx),
        .hit_count(s_hit_count), .access_count(s_access_count),
        .recency_order(s_recency_order)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model
    logic [31:0] m_tag [N];
    bit          m_valid [N];
    int          m_order [N];
    int          m_hits = 0;
    int          m_accesses = 0;

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] model_order_flat();
        logic [23:0] v = '0;
        for (int s = 0; s < N; s++) v[s*3 +: 3] = 3'(m_order[s]);
        return v;
    endfunction

    function automatic bit order_is_perm(input logic [23:0] v);
        bit [N-1:0] seen = '0;
        for (int s = 0; s < N; s++) seen[v[s*3 +: 3]] = 1'b1;
        return &seen;
    endfunction

    task automatic model_reset();
        for (int e = 0; e < N; e++) begin
            m_tag[e] = '0;
            m_valid[e] = 0;
            m_order[e] = N - 1 - e;
        end
        m_hits = 0;
        m_accesses = 0;
    endtask

    task automatic model_touch(input int idx);
        int pos = 0;
        for (int s = 0; s < N; s++) if (m_order[s] == idx) pos = s;
        for (int s = pos; s > 0; s--) m_order[s] = m_order[s-1];
        m_order[0] = idx;
    endtask

    // drive at negedge; response valid after the next posedge
    task automatic access(input logic [31:0] addr, input string tag);
        bit exp_hit = 0;
        int exp_idx = m_order[N-1];
        for (int e = N - 1; e >= 0; e--) begin
            if (m_valid[e] && m_tag[e] == addr) begin
                exp_hit = 1;
                exp_idx = e;
            end
        end
        req_valid = 1'b1;
        req_addr  = addr;
        @(posedge clk);
        #1;
        if (!exp_hit) begin
            m_tag[exp_idx] = addr;
            m_valid[exp_idx] = 1;
        end else begin
            m_hits++;
        end
        m_accesses++;
        model_touch(exp_idx);
        check("R2", {tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check(exp_hit ? "R3" : "R6", {tag, " rsp_hit"}, 64'(rsp_hit), 64'(exp_hit));
        check(exp_hit ? "R3" : "R6", {tag, " rsp_idx"}, 64'(rsp_idx), 64'(exp_idx));
        check(exp_hit ? "R5" : "R6", {tag, " order"}, 64'(recency_order), 64'(model_order_flat()));
        check("R10", {tag, " permutation"}, 64'(order_is_perm(recency_order)), 64'd1);
        check("R8", {tag, " access_count"}, 64'(access_count), 64'(m_accesses));
        check("R8", {tag, " hit_count"}, 64'(hit_count), 64'(m_hits));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            check("R2", "idle rsp_valid", 64'(rsp_valid), 64'd0);
            check("R8", "idle access_count", 64'(access_count), 64'(m_accesses));
            @(negedge clk);
        end
    endtask

    function automatic int min_sat(input int v);
        return (v > (1 << SMALL_W) - 1) ? (1 << SMALL_W) - 1 : v;
    endfunction

    initial begin
        process::self().srandom(32'd1234);
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", "reset access_count", 64'(access_count), 64'd0);
        check("R1", "reset hit_count", 64'(hit_count), 64'd0);
        check("R1", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1", "reset order", 64'(recency_order), 64'(24'o01234567));
        @(negedge clk);

        // R4: address zero after reset must miss and take entry 0 (slot 7)
        access(32'h0, "R4 addr0");
        check("R4", "addr0 miss", 64'(rsp_hit), 64'd0);
        // R7: immediate repeat sees the refill
        access(32'h0, "R7 repeat");
        check("R7", "back-to-back hit", 64'(rsp_hit), 64'd1);

        // directed: fill all entries, then hit in the middle of the list
        for (int k = 1; k <= 8; k++) access(32'h1000 + 32'(k*4), "fill");
        access(32'h1000 + 32'd12, "R5 mid hit");
        access(32'h1000 + 32'd32, "R5 front hit");
        access(32'h2000, "R6 evict");
        idle(3);

        // looping trace of 20 words: every access misses under LRU with 8 entries
        for (int r = 0; r < 3; r++)
            for (int k = 0; k < 20; k++) access(32'h4000 + 32'(k*4), "loop");

        // constrained random from a small pool mixed with idle gaps
        for (int k = 0; k < 600; k++) begin
            access(32'h8000 + 32'(($urandom % 12) * 4), "random");
            if (($urandom % 8) == 0) idle(1);
        end

        // R9 saturation on the narrow-counter instance
        check("R9", "small access_count saturates", 64'(s_access_count), 64'(min_sat(m_accesses)));
        check("R9", "small hit_count saturates", 64'(s_hit_count), 64'(min_sat(m_hits)));
        access(32'h8000, "R9 extra");
        check("R9", "small access_count holds", 64'(s_access_count), 64'((1 << SMALL_W) - 1));

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule